// File: doc/BRIEF.md
# Virtual Processor Register Address Mapper

This block sits beside one cluster's physical register file inside a lane and turns a virtual processor's logical register number into the physical row it occupies. The register file is split at run time. A region at the bottom holds the shared registers, which every virtual processor on the lane uses. Above it the file holds one private window per virtual processor. Software sets the split with a configuration write that carries a shared count and a private count. The write is made before a loop starts. Register contents are not preserved across a change.

From the stored split the block works out how many virtual processors fit in the lane. This is the free space above the shared region divided by the private window size, rounded down and clamped to the slot limit of the lane. Each lookup presents a slot number and a logical index. The block returns the physical address, or raises an illegal flag when the index lies outside the configured register set or the slot is beyond the capacity.

Top module: `vp_reg_mapper`

## Requirements
- R1: After reset the configuration is 0 shared and NUM_PREGS private registers, so vp_cap_o is 1 and slot 0 may use every index.
- R2: vp_cap_o equals floor((NUM_PREGS - shared) / private), limited to MAX_VP. With 32 registers: 0/8 gives 4, 4/4 gives 7 and 7/1 gives 25.
- R3: A legal lookup whose index is below the shared count returns the index unchanged, whatever the slot.
- R4: A legal lookup whose index is at or above the shared count returns slot × private + index. This equals shared + slot × private + (index − shared).
- R5: An index at or above shared + private sets illegal_o and drives paddr_o to 0.
- R6: A slot at or above vp_cap_o sets illegal_o and drives paddr_o to 0.
- R7: A configuration write with a private count of 0 is dropped and the previous configuration stays in force.
- R8: A configuration write with shared + private above NUM_PREGS is dropped and the previous configuration stays in force.
- R9: An accepted configuration write changes the lookups and vp_cap_o from the first clock edge after the write. Before that edge they still follow the old configuration.
- R10: While cfg_we_i is low, the configuration inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_shared_i | input | CNT_W | Requested shared register count |
| cfg_private_i | input | CNT_W | Requested private registers per VP |
| slot_i | input | SLOT_W | VP slot of the lookup |
| lreg_i | input | PREG_W | Logical register index of the lookup |
| paddr_o | output | PREG_W | Physical register address, 0 when illegal |
| illegal_o | output | 1 | Lookup outside register set or capacity |
| vp_cap_o | output | CAP_W | VPs the lane holds under the current split |

## Verification
The bench builds two copies of the block, both with 32 physical registers. The main copy uses a limit of 32 slots. With that limit, every split from one private register up to a single 32-register window can be reached, including the topmost physical address and the edges of the slot range. The second copy limits the lane to 16 slots. Small private windows then produce a quotient above the limit, which exercises the clamp on the capacity and the last slot below it.

// File: rtl/vpmap_pkg.sv
package vpmap_pkg;
  typedef enum logic [1:0] {
    MAP_SHARED  = 2'd0,
    MAP_PRIVATE = 2'd1,
    MAP_ILLEGAL = 2'd2
  } map_kind_e;
endpackage

// File: rtl/vpmap_div.sv
// Combinational restoring divider, one stage per quotient bit.
module vpmap_div #(
  parameter int W = 6
) (
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] quo_o
);
  logic [W-1:0] rem_s [W];
  logic [W:0]   trial [W];

  assign rem_s[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_stage
    assign trial[i] = {rem_s[i], num_i[W-1-i]};
    assign quo_o[W-1-i] = (trial[i] >= {1'b0, den_i});
    if (i < W-1) begin : g_rem
      assign rem_s[i+1] = quo_o[W-1-i] ? W'(trial[i] - {1'b0, den_i})
                                       : trial[i][W-1:0];
    end
  end
endmodule

// File: rtl/vpmap_cfg.sv
// Holds the accepted split and the capacity derived from it.
module vpmap_cfg #(
  parameter int NUM_PREGS = 32,
  parameter int MAX_VP    = 32,
  parameter int CNT_W     = 6,
  parameter int CAP_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] shared_i,
  input  logic [CNT_W-1:0] private_i,
  output logic [CNT_W-1:0] shared_o,
  output logic [CNT_W-1:0] private_o,
  output logic [CAP_W-1:0] cap_o
);
  logic [CNT_W:0]   span;
  logic             accept;
  logic [CNT_W-1:0] free_regs;
  logic [CNT_W-1:0] quo;
  logic [CAP_W-1:0] cap_next;

  assign span      = {1'b0, shared_i} + {1'b0, private_i};
  assign accept    = we_i && (private_i != '0) && (span <= (CNT_W+1)'(NUM_PREGS));
  assign free_regs = CNT_W'(NUM_PREGS) - shared_i;

  vpmap_div #(.W(CNT_W)) u_div (
    .num_i (free_regs),
    .den_i (private_i),
    .quo_o (quo)
  );

  assign cap_next = (quo > CNT_W'(MAX_VP)) ? CAP_W'(MAX_VP) : CAP_W'(quo);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shared_o  <= '0;
      private_o <= CNT_W'(NUM_PREGS);
      cap_o     <= CAP_W'(1);
    end else if (accept) begin
      shared_o  <= shared_i;
      private_o <= private_i;
      cap_o     <= cap_next;
    end
  end
endmodule

// File: rtl/vpmap_xlate.sv
// Logical-to-physical register translation against the stored split.
module vpmap_xlate
  import vpmap_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int CAP_W  = 6,
  parameter int SLOT_W = 5,
  parameter int PREG_W = 5
) (
  input  logic [CNT_W-1:0]  shared_i,
  input  logic [CNT_W-1:0]  private_i,
  input  logic [CAP_W-1:0]  cap_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [PREG_W-1:0] lreg_i,
  output map_kind_e         kind_o,
  output logic [PREG_W-1:0] paddr_o
);
  localparam int CALC_W = SLOT_W + CNT_W + 1;

  logic [CNT_W:0]  win_end;
  logic            idx_ok;
  logic            slot_ok;
  logic            in_shared;
  logic [CALC_W-1:0] priv_addr;

  assign win_end   = {1'b0, shared_i} + {1'b0, private_i};
  assign idx_ok    = (CNT_W+1)'(lreg_i) < win_end;
  assign slot_ok   = CAP_W'(slot_i) < cap_i;
  assign in_shared = CNT_W'(lreg_i) < shared_i;
  // shared + slot*private + (idx - shared) reduces to slot*private + idx
  assign priv_addr = CALC_W'(slot_i) * CALC_W'(private_i) + CALC_W'(lreg_i);

  always_comb begin
    if (!idx_ok || !slot_ok) begin
      kind_o  = MAP_ILLEGAL;
      paddr_o = '0;
    end else if (in_shared) begin
      kind_o  = MAP_SHARED;
      paddr_o = lreg_i;
    end else begin
      kind_o  = MAP_PRIVATE;
      paddr_o = PREG_W'(priv_addr);
    end
  end
endmodule

// File: rtl/vp_reg_mapper.sv
module vp_reg_mapper
  import vpmap_pkg::*;
#(
  parameter  int NUM_PREGS = 32,
  parameter  int MAX_VP    = 32,
  localparam int PREG_W    = $clog2(NUM_PREGS),
  localparam int CNT_W     = $clog2(NUM_PREGS + 1),
  localparam int SLOT_W    = $clog2(MAX_VP),
  localparam int CAP_W     = $clog2(MAX_VP + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CNT_W-1:0]  cfg_shared_i,
  input  logic [CNT_W-1:0]  cfg_private_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [PREG_W-1:0] lreg_i,
  output logic [PREG_W-1:0] paddr_o,
  output logic              illegal_o,
  output logic [CAP_W-1:0]  vp_cap_o
);
  logic [CNT_W-1:0] cur_shared;
  logic [CNT_W-1:0] cur_private;
  map_kind_e        kind;

  vpmap_cfg #(
    .NUM_PREGS (NUM_PREGS),
    .MAX_VP    (MAX_VP),
    .CNT_W     (CNT_W),
    .CAP_W     (CAP_W)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .shared_i  (cfg_shared_i),
    .private_i (cfg_private_i),
    .shared_o  (cur_shared),
    .private_o (cur_private),
    .cap_o     (vp_cap_o)
  );

  vpmap_xlate #(
    .CNT_W  (CNT_W),
    .CAP_W  (CAP_W),
    .SLOT_W (SLOT_W),
    .PREG_W (PREG_W)
  ) u_xlate (
    .shared_i  (cur_shared),
    .private_i (cur_private),
    .cap_i     (vp_cap_o),
    .slot_i    (slot_i),
    .lreg_i    (lreg_i),
    .kind_o    (kind),
    .paddr_o   (paddr_o)
  );

  assign illegal_o = (kind == MAP_ILLEGAL);
endmodule

// File: rtl/vp_reg_mapper_chk.sv
module vp_reg_mapper_chk #(
  parameter int NUM_PREGS = 32,
  parameter int MAX_VP    = 32,
  parameter int PREG_W    = 5,
  parameter int CNT_W     = 6,
  parameter int SLOT_W    = 5,
  parameter int CAP_W     = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [CNT_W-1:0]  cfg_shared_i,
  input logic [CNT_W-1:0]  cfg_private_i,
  input logic [SLOT_W-1:0] slot_i,
  input logic [PREG_W-1:0] lreg_i,
  input logic [PREG_W-1:0] paddr_o,
  input logic              illegal_o,
  input logic [CAP_W-1:0]  vp_cap_o,
  input logic [CNT_W-1:0]  cur_shared,
  input logic [CNT_W-1:0]  cur_private
);
  logic wr_ok;
  assign wr_ok = cfg_we_i && (cfg_private_i != '0) &&
                 (int'(cfg_shared_i) + int'(cfg_private_i) <= NUM_PREGS);

  assert_cap_fits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vp_cap_o != '0 && int'(vp_cap_o) <= MAX_VP &&
    int'(vp_cap_o) * int'(cur_private) + int'(cur_shared) <= NUM_PREGS);

  assert_shared_identity_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(lreg_i) < int'(cur_shared) && int'(slot_i) < int'(vp_cap_o))
      |-> (!illegal_o && paddr_o == lreg_i));

  assert_illegal_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> paddr_o == '0);

  assert_slot_limit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(slot_i) >= int'(vp_cap_o) |-> illegal_o);

  assert_zero_private_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_private_i == '0) |=> ($stable(cur_private) && $stable(vp_cap_o)));

  assert_oversize_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && int'(cfg_shared_i) + int'(cfg_private_i) > NUM_PREGS)
      |=> ($stable(cur_shared) && $stable(cur_private)));

  assert_apply_next_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> (cur_shared == $past(cfg_shared_i) && cur_private == $past(cfg_private_i)));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> ($stable(cur_shared) && $stable(cur_private) && $stable(vp_cap_o)));
endmodule

bind vp_reg_mapper vp_reg_mapper_chk #(
  .NUM_PREGS (NUM_PREGS),
  .MAX_VP    (MAX_VP),
  .PREG_W    (PREG_W),
  .CNT_W     (CNT_W),
  .SLOT_W    (SLOT_W),
  .CAP_W     (CAP_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_we_i      (cfg_we_i),
  .cfg_shared_i  (cfg_shared_i),
  .cfg_private_i (cfg_private_i),
  .slot_i        (slot_i),
  .lreg_i        (lreg_i),
  .paddr_o       (paddr_o),
  .illegal_o     (illegal_o),
  .vp_cap_o      (vp_cap_o),
  .cur_shared    (cur_shared),
  .cur_private   (cur_private)
);

// File: tb/sim_vp_reg_mapper.sv
module sim_vp_reg_mapper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_s = '0;
  logic [5:0] cfg_p = '0;
  logic [4:0] slot = '0;
  logic [4:0] lreg = '0;
  logic [3:0] slot1 = '0;
  logic [4:0] paddr, paddr1;
  logic       ill, ill1;
  logic [5:0] cap;
  logic [4:0] cap1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vp_reg_mapper #(.NUM_PREGS(32), .MAX_VP(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_shared_i(cfg_s),
    .cfg_private_i(cfg_p), .slot_i(slot), .lreg_i(lreg),
    .paddr_o(paddr), .illegal_o(ill), .vp_cap_o(cap));

  vp_reg_mapper #(.NUM_PREGS(32), .MAX_VP(16)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_shared_i(cfg_s),
    .cfg_private_i(cfg_p), .slot_i(slot1), .lreg_i(lreg),
    .paddr_o(paddr1), .illegal_o(ill1), .vp_cap_o(cap1));

  // shared, private, slot, index, exp addr, exp illegal, exp capacity
  localparam int NV = 14;
  localparam int VEC [NV][7] = '{
    '{ 0,  8,  3,  5, 29, 0,  4},
    '{ 0,  8,  4,  0,  0, 1,  4},
    '{ 4,  4,  6,  7, 31, 0,  7},
    '{ 4,  4,  2,  3,  3, 0,  7},
    '{ 4,  4,  0,  8,  0, 1,  7},
    '{ 7,  1, 24,  7, 31, 0, 25},
    '{ 7,  1, 25,  7,  0, 1, 25},
    '{ 0,  1, 31,  0, 31, 0, 32},
    '{ 5,  3,  8,  6, 30, 0,  9},
    '{31,  1,  0, 31, 31, 0,  1},
    '{31,  1,  0, 30, 30, 0,  1},
    '{10,  5,  3, 12, 27, 0,  4},
    '{10,  5,  3, 15,  0, 1,  4},
    '{ 0, 32,  0, 31, 31, 0,  1}
  };

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(int s, int p);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_s  = 6'(s);
    cfg_p  = 6'(p);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(int sl, int ix);
    slot = 5'(sl);
    lreg = 5'(ix);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    lookup(0, 31);
    check("R1 cap", int'(cap), 1);
    check("R1 addr", int'(paddr), 31);
    check("R1 ill", int'(ill), 0);
    lookup(1, 0);
    check("R1 slot1 ill (R6)", int'(ill), 1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      write_cfg(VEC[i][0], VEC[i][1]);
      lookup(VEC[i][2], VEC[i][3]);
      if (VEC[i][5] != 0)
        tag = (VEC[i][2] >= VEC[i][6]) ? "R6" : "R5";
      else
        tag = (VEC[i][3] < VEC[i][0]) ? "R3" : "R4";
      check({tag, " addr"}, int'(paddr), VEC[i][4]);
      check({tag, " ill"}, int'(ill), VEC[i][5]);
      check("R2 cap", int'(cap), VEC[i][6]);
    end

    // R7 zero private rejected; config is 0/32 from last vector
    write_cfg(4, 4);
    write_cfg(2, 0);
    lookup(6, 7);
    check("R7 cap", int'(cap), 7);
    check("R7 addr", int'(paddr), 31);

    // R8 oversize rejected
    write_cfg(20, 13);
    lookup(6, 7);
    check("R8 cap", int'(cap), 7);
    check("R8 addr", int'(paddr), 31);

    // R10 inputs ignored without strobe
    @(negedge clk);
    cfg_s = 6'd0;
    cfg_p = 6'd1;
    repeat (2) @(negedge clk);
    lookup(6, 7);
    check("R10 cap", int'(cap), 7);
    check("R10 addr", int'(paddr), 31);

    // R9 takes effect only after the edge
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_s  = 6'd0;
    cfg_p  = 6'd8;
    lookup(6, 7);
    check("R9 before cap", int'(cap), 7);
    check("R9 before addr", int'(paddr), 31);
    @(negedge clk);
    cfg_we = 1'b0;
    lookup(3, 5);
    check("R9 after cap", int'(cap), 4);
    check("R9 after addr", int'(paddr), 29);

    // R2 clamp on the 16-slot copy
    write_cfg(0, 1);
    slot1 = 4'd15;
    lookup(0, 0);
    check("R2 clamp cap", int'(cap1), 16);
    check("R4 clamp addr", int'(paddr1), 15);
    check("R4 clamp ill", int'(ill1), 0);
    write_cfg(7, 1);
    slot1 = 4'd15;
    lookup(0, 7);
    check("R2 clamp cap 7/1", int'(cap1), 16);
    check("R4 clamp addr 7/1", int'(paddr1), 22);

    finish_run();
  end
endmodule